// File: doc/BRIEF.md
# Byte-Wide Asynchronous NVRAM Controller

This controller sits between a synchronous host and an external non-volatile memory that has an SRAM-style asynchronous interface. The memory has 21 address lines, an 8-bit data bus and three active-low strobes: select, write and output enable. The host issues single-byte reads or writes over a request/acknowledge handshake. It holds `req` high with stable fields until it sees either `ack` or `err`.

After the memory supply is reported good, the controller keeps every strobe inactive for a timed startup window before it starts any access. It restarts that window from zero whenever the supply-good input drops, whether this happens during startup, while idle, or in the middle of an access. An access cut short by a supply drop ends with an error pulse instead of an acknowledge. Strobe timing is counted in clock cycles derived from the clock frequency and the memory access time. An idle cycle always separates two accesses, so the controller's data driver and the memory's output are never both active.

The data pad buffer sits at the chip boundary. The controller exposes the bus as separate output, output-enable and input signals.

Top module: `nvram_ctrl`

## Requirements
- R1: While reset is asserted, and while the synchronised supply-good is low, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, and `ack` and `err` are 0.
- R2: After `supply_ok` rises and stays high, no access starts until HOLD_CYC = CLK_MHZ*STARTUP_US cycles have been counted. With a two-stage synchroniser, the first access starts N+3 clock edges after the rise at the earliest.
- R3: Any low level on `supply_ok` restarts the startup count from zero. This applies during the startup window and after an aborted access.
- R4: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly ACC_CYC = ceil(ACCESS_NS*CLK_MHZ/1000) cycles. The memory data is captured on the edge that ends the read and is presented on `rdata`.
- R5: A write holds `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for exactly ACC_CYC cycles. `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, and `mem_dq_out` carries the accepted write byte.
- R6: `ack` is a one-cycle pulse in the cycle after the access ends, and `rdata` is valid while `ack` is high.
- R7: `mem_oe_n` is never 0 while `mem_dq_oe` is 1, and never falls in the cycle right after `mem_dq_oe` was 1. A cycle with `mem_ce_n`=1 separates any two accesses.
- R8: The address and write data are registered when the request is accepted. Changes on `req_addr` and `req_wdata` during an access have no effect on `mem_addr` or `mem_dq_out`.
- R9: A supply-good drop during an access ends it within three cycles. All strobes go high, `mem_dq_oe` goes to 0, `err` pulses for one cycle, and `ack` is not given for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Asynchronous memory supply-good indication |
| req | input | 1 | Host request, held until ack or err |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse on supply loss |
| rdata | output | 8 | Read byte, valid with ack |
| mem_addr | output | 21 | Memory address lines |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_in | input | 8 | Data from the memory pad |

## Verification
The bench measures the delay from a supply-good rise to the first strobe, both at cold start and after a drop in mid-window. A controller that kept a partial count, or never cleared it, would open the bus too early. It cuts the supply in the middle of a read and in the middle of a write. A design that kept driving the bus, raised `ack` or left a strobe low would be caught there. It runs back-to-back writes and reads at address 0, at the top address, and across a small random address pool. It changes the request fields during every access. These runs expose a missing turnaround cycle, an access shorter than the access time, unregistered address or data, and read data taken on the wrong edge.

// File: rtl/nvram_ctrl.sv
module nvram_ctrl #(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 200,
  parameter int STARTUP_US = 2000,
  parameter int ACCESS_NS  = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int HOLD_CYC = CLK_MHZ * STARTUP_US;
  localparam int ACC_RAW  = (ACCESS_NS * CLK_MHZ + 999) / 1000;
  localparam int ACC_CYC  = (ACC_RAW < 1) ? 1 : ACC_RAW;
  localparam int CNT_MAX  = (HOLD_CYC > ACC_CYC) ? HOLD_CYC : ACC_CYC;
  localparam int CW       = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {ST_HOLD, ST_IDLE, ST_RD, ST_WR, ST_TURN} state_t;

  state_t        st, st_d;
  logic [CW-1:0] cnt;
  logic [1:0]    sync;
  logic          sok;
  logic          hold_done, acc_done, active;

  assign sok       = sync[1];
  assign hold_done = (cnt == CW'(HOLD_CYC - 1));
  assign acc_done  = (cnt == CW'(ACC_CYC - 1));
  assign active    = (st == ST_RD) || (st == ST_WR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], supply_ok};

  always_comb begin
    st_d = st;
    if (!sok) st_d = ST_HOLD;
    else begin
      case (st)
        ST_HOLD: if (hold_done) st_d = ST_IDLE;
        ST_IDLE: if (req) st_d = req_we ? ST_WR : ST_RD;
        ST_RD,
        ST_WR:   if (acc_done) st_d = ST_TURN;
        ST_TURN: st_d = ST_IDLE;
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_HOLD;
      cnt        <= '0;
      ack        <= 1'b0;
      err        <= 1'b0;
      rdata      <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      st        <= st_d;
      ack       <= 1'b0;
      err       <= !sok && active;
      mem_ce_n  <= !((st_d == ST_RD) || (st_d == ST_WR));
      mem_we_n  <= (st_d != ST_WR);
      mem_oe_n  <= (st_d != ST_RD);
      mem_dq_oe <= (st_d == ST_WR);
      if (!sok) cnt <= '0;
      else begin
        case (st)
          ST_HOLD: cnt <= hold_done ? '0 : cnt + 1'b1;
          ST_IDLE: begin
            cnt <= '0;
            if (req) begin
              mem_addr   <= req_addr;
              mem_dq_out <= req_wdata;
            end
          end
          ST_RD, ST_WR: begin
            if (acc_done) begin
              cnt <= '0;
              ack <= 1'b1;
              if (st == ST_RD) rdata <= mem_dq_in;
            end else cnt <= cnt + 1'b1;
          end
          default: cnt <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/nvram_ctrl_chk.sv
module nvram_ctrl_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sok,
  input logic              ack,
  input logic              err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R7
  AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7
  AST_IDLE_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(mem_ce_n, 2)); // R7
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n)); // R5
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R6
  AST_ERR_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && err)); // R9
  AST_SUPPLY_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sok |=> (mem_ce_n && mem_we_n && !mem_dq_oe)); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8
endmodule

bind nvram_ctrl nvram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sok(sok), .ack(ack), .err(err),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/nvram_ctrl_tb.sv
module nvram_ctrl_tb;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int CLK_MHZ = 200;
  localparam int STARTUP_US = 1;
  localparam int N = CLK_MHZ * STARTUP_US;
  localparam int ACC = (35 * CLK_MHZ + 999) / 1000;

  logic clk = 0, rst_n = 0, supply_ok = 0;
  logic req = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ack, err;
  logic [DW-1:0] rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  nvram_ctrl #(.CLK_MHZ(CLK_MHZ), .STARTUP_US(STARTUP_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .err(err), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b101, a[20:16]};
  endfunction

  logic [DW-1:0] mem [int];
  logic [DW-1:0] ref_mem [int];

  always @(posedge clk) begin
    cyc++;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;
    if (cyc > 100000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk)
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : init_val(mem_addr);
    else mem_dq_in <= 8'h00;

  int run = 0, last_len = 0;
  bit prev_oe = 0, prev_ack = 0, prev_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n && mem_dq_oe) chk(0, "R7 contention", 1, 0);
      if (!mem_oe_n && prev_oe) chk(0, "R7 turnaround", 1, 0);
      if (!mem_ce_n && mem_dq_oe != !mem_we_n) chk(0, "R5 driver window", mem_dq_oe, !mem_we_n);
      if (ack && prev_ack) chk(0, "R6 ack width", 2, 1);
      if (err && prev_err) chk(0, "R9 err width", 2, 1);
    end
    if (!mem_ce_n) run++;
    else if (run != 0) begin last_len = run; run = 0; end
    prev_oe = mem_dq_oe; prev_ack = ack; prev_err = err;
  end

  int start_cyc;
  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int res);
    bit scr = 0;
    res = 0; rd = '0;
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!mem_ce_n && !scr) begin
        start_cyc = cyc;
        chk(mem_addr == a, "R8 address latched", mem_addr, a);
        req_addr = ~a; req_wdata = ~d; scr = 1;
      end
      if (mem_dq_oe) chk(mem_dq_out == d, "R5 R8 write data", mem_dq_out, d);
      if (ack || err) begin
        res = ack ? 1 : 2; rd = rdata;
        break;
      end
    end
    req = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] rd; int res;
    access(1, a, d, rd, res);
    chk(res == 1, "R6 write ack", res, 1);
    @(negedge clk);
    chk(last_len == ACC, "R5 write length", last_len, ACC);
    ref_mem[int'(a)] = d;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a);
    logic [DW-1:0] rd, exp; int res;
    exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
    access(0, a, 8'h00, rd, res);
    chk(res == 1, "R6 read ack", res, 1);
    chk(rd == exp, "R4 read data", rd, exp);
    @(negedge clk);
    chk(last_len == ACC, "R4 read length", last_len, ACC);
  endtask

  task automatic raise_and_measure(input string tag);
    int t0;
    @(negedge clk); supply_ok = 1; t0 = cyc;
    wr(21'h0ABCD, 8'h3C);
    chk((start_cyc - t0 >= N) && (start_cyc - t0 <= N + 4), tag, start_cyc - t0, N + 3);
  endtask

  initial begin
    logic [AW-1:0] pool [8];
    logic [DW-1:0] rd; int res;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ack, err} == 6'b111000, "R1 reset state",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ack, err}, 6'b111000);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110, "R1 no supply idle",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

    raise_and_measure("R2 startup delay");
    rd_chk(21'h0ABCD);

    wr(21'h000000, 8'h00); wr(21'h1FFFFF, 8'hFF);
    rd_chk(21'h000000); rd_chk(21'h1FFFFF);
    rd_chk(21'h012345);
    wr(21'h000055, 8'hA5); rd_chk(21'h000055); wr(21'h000055, 8'h5A); rd_chk(21'h000055);

    for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 5 == 0) ? AW'($urandom) : pool[$urandom % 8];
      if ($urandom % 2) wr(a, DW'($urandom)); else rd_chk(a);
    end

    fork
      access(0, 21'h00777, 8'h00, rd, res);
      begin wait (!mem_ce_n); repeat (2) @(negedge clk); supply_ok = 0; end
    join
    chk(res == 2, "R9 read abort err", res, 2);
    @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110, "R9 strobes released",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    repeat (10) @(negedge clk);
    raise_and_measure("R3 restart after read abort");

    fork
      access(1, 21'h00999, 8'hC3, rd, res);
      begin wait (!mem_dq_oe); wait (mem_dq_oe); repeat (2) @(negedge clk); supply_ok = 0; end
    join
    chk(res == 2, "R9 write abort err", res, 2);
    @(negedge clk);
    chk(mem_dq_oe == 0 && mem_ce_n && mem_we_n, "R9 driver released", mem_dq_oe, 0);
    repeat (5) @(negedge clk);

    @(negedge clk); supply_ok = 1;
    repeat (N / 2) @(negedge clk);
    supply_ok = 0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n, "R3 hold during window", {mem_ce_n, mem_we_n}, 2'b11);
    raise_and_measure("R3 full window after glitch");
    rd_chk(21'h0ABCD);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule